// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block is the per-processor side of an interrupt controller. A selector elsewhere picks the best enabled pending source and hands its ID to this unit. The unit applies its own priority mask and enable, drives the request line to the processor, and services two register actions. Reading the acknowledge register claims the offered interrupt. Writing an ID to the completion register retires that interrupt. A value of 1023 means "no interrupt" everywhere in the unit.

Interrupts nest. Each acknowledged ID stores the ID it preempted in a per-ID link, so the running interrupts form a chain that ends in 1023. Completing the running interrupt restores its link as the running ID, together with that link's priority. Completing an interrupt that is not running removes it from the middle of the chain. This walk takes one cycle per hop, and a busy output is high while it runs. When a completed source is level-sensitive, enabled and still raised, the unit sends a re-pend strobe back to the state registers. A successful acknowledge sends a clear-pending strobe.

Bus accesses are edge-detected on a request strobe. Each rising edge performs exactly one access, and read data is registered and valid on the cycle after that edge.

Top module: `aic_unit`

## Requirements
- R1: After reset the control register reads 0, the priority mask reads 0x0F0 and the running priority reads 0x100. The highest-pending and acknowledge registers read 1023.
- R2: Register offsets are: control at 0x00 (bit 0 enables the interface), priority mask at 0x04 (bits 9:0 stored, upper bits dropped), binary point at 0x08 (reads 0, writes have no effect), acknowledge read at 0x0C, completion write at 0x10 (ID in bits 9:0), running priority at 0x14 and highest pending at 0x18. Any other offset reads 0.
- R3: The highest-pending register reads the offered ID when the interface is enabled, the ID is below the source count and its priority is at most the mask. Otherwise it reads 1023. `irq_req` is high exactly when such an ID also has a priority strictly below the running priority.
- R4: An acknowledge read returns 1023 and changes nothing when no ID qualifies under R3 or when its priority is not strictly below the running priority.
- R5: A successful acknowledge returns the ID and makes it the running ID, with its priority as the running priority. It pulses `clr_pend_vld` with that ID on the cycle after the access, and `irq_req` falls.
- R6: A request strobe held high for several cycles performs one access only.
- R7: A completion write is ignored while the running ID is 1023.
- R8: Completing the running ID makes its link the running ID. The running priority becomes 0x100 when that link is 1023 and the link's priority otherwise.
- R9: Completing a non-running ID walks the chain from the running ID and splices the completed ID out of it. The running ID stays unchanged, `bus_busy` is high during the walk, and accesses made while busy are dropped.
- R10: On a completion that is not ignored, `repend_vld` pulses with the ID on the next cycle if that source is enabled, not edge-configured and its level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe, acts on its rising edge |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_busy | output | 1 | Chain walk in progress |
| pend_id | input | 10 | Best pending ID from the selector, 1023 if none |
| prio_flat | input | NUM_IRQ*PRIO_W | Priority of every source, ID i at bits i*PRIO_W |
| src_enabled | input | NUM_IRQ | Per-source enable |
| src_edge | input | NUM_IRQ | Per-source edge configuration |
| src_level | input | NUM_IRQ | Per-source raw input level |
| irq_req | output | 1 | Interrupt request to the processor |
| clr_pend_vld | output | 1 | Clear-pending strobe |
| clr_pend_id | output | 10 | ID to clear |
| repend_vld | output | 1 | Re-pend strobe |
| repend_id | output | 10 | ID to re-pend |

## Verification
On every cycle the assertions check several invariants. A clear-pending strobe always names the new running ID and never lasts two cycles. An idle running ID always carries priority 0x100. The running ID does not move while the walk is busy. The request stays low while the interface is disabled. A re-pend only follows a completion made while some interrupt was running. The bench scenarios show behaviour that spans several accesses: priorities restored in nested order, the chain staying intact after a splice from its middle, accesses dropped during a walk, the masking thresholds, and the exact read values of every register.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_MASK = 5'h04;
  localparam logic [4:0] OFS_BPNT = 5'h08;
  localparam logic [4:0] OFS_ACK  = 5'h0C;
  localparam logic [4:0] OFS_EOI  = 5'h10;
  localparam logic [4:0] OFS_RUNP = 5'h14;
  localparam logic [4:0] OFS_HPND = 5'h18;

  localparam logic [ID_W-1:0] MASK_RESET = 10'h0F0;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_e;
endpackage

// File: rtl/aic_prio_lookup.sv
module aic_prio_lookup
  import aic_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic [ID_W-1:0]           idx,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic [PRIO_W-1:0]         prio,
  output logic                      known
);
  // Priority of the addressed source; zero and unknown when out of range.
  always_comb begin
    prio  = '0;
    known = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (idx == ID_W'(i)) begin
        prio  = prio_flat[i*PRIO_W +: PRIO_W];
        known = 1'b1;
      end
    end
  end
endmodule

// File: rtl/aic_qualify.sv
module aic_qualify
  import aic_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              cpu_en,
  input  logic [ID_W-1:0]   mask,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_known,
  input  logic [PRIO_W:0]   run_prio,
  output logic [ID_W-1:0]   hp_id,
  output logic              ack_ok
);
  logic hp_valid;

  always_comb begin
    hp_valid = cpu_en && pend_known && (32'(pend_prio) <= 32'(mask));
    hp_id    = hp_valid ? pend_id : ID_NONE;
    ack_ok   = hp_valid && (32'(pend_prio) < 32'(run_prio));
  end
endmodule

// File: rtl/aic_link_store.sv
module aic_link_store
  import aic_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] widx,
  input  logic [ID_W-1:0] wval,
  input  logic [ID_W-1:0] idx_a,
  output logic [ID_W-1:0] val_a,
  input  logic [ID_W-1:0] idx_b,
  output logic [ID_W-1:0] val_b
);
  logic [NUM_IRQ*ID_W-1:0] flat;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ent
    logic [ID_W-1:0] ent_q;
    logic            ent_en;
    assign ent_en = we && (widx == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= ID_NONE;
      end else if (ent_en) begin
        ent_q <= wval;
      end
    end
    assign flat[g*ID_W +: ID_W] = ent_q;
  end

  always_comb begin
    val_a = ID_NONE;
    val_b = ID_NONE;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (idx_a == ID_W'(i)) val_a = flat[i*ID_W +: ID_W];
      if (idx_b == ID_W'(i)) val_b = flat[i*ID_W +: ID_W];
    end
  end
endmodule

// File: rtl/aic_chain_ctl.sv
module aic_chain_ctl
  import aic_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_fire,
  input  logic [ID_W-1:0]   ack_id,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic              eoi_fire,
  input  logic [ID_W-1:0]   eoi_id,
  input  logic [ID_W-1:0]   link_a,
  input  logic [ID_W-1:0]   link_b,
  input  logic [PRIO_W-1:0] link_a_prio,
  input  logic              link_a_known,
  output logic [ID_W-1:0]   run_id,
  output logic [PRIO_W:0]   run_prio,
  output logic              busy,
  output logic              eoi_take,
  output logic [ID_W-1:0]   idx_a,
  output logic [ID_W-1:0]   idx_b,
  output logic              lk_we,
  output logic [ID_W-1:0]   lk_widx,
  output logic [ID_W-1:0]   lk_wval
);
  localparam int RP_W  = PRIO_W + 1;
  localparam int CNT_W = $clog2(NUM_IRQ + 1);
  localparam logic [RP_W-1:0]  RP_IDLE   = {1'b1, {PRIO_W{1'b0}}};
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(NUM_IRQ - 1);

  walk_e            walk_q, walk_d;
  logic [ID_W-1:0]  cur_q, cur_d;
  logic [ID_W-1:0]  tgt_q, tgt_d;
  logic [CNT_W-1:0] steps_q, steps_d;
  logic [ID_W-1:0]  run_id_q, run_id_d;
  logic [RP_W-1:0]  run_prio_q, run_prio_d;

  always_comb begin
    walk_d     = walk_q;
    cur_d      = cur_q;
    tgt_d      = tgt_q;
    steps_d    = steps_q;
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    lk_we      = 1'b0;
    lk_widx    = ack_id;
    lk_wval    = run_id_q;
    eoi_take   = eoi_fire && (run_id_q != ID_NONE) && (walk_q == WALK_IDLE);
    idx_a      = (walk_q == WALK_RUN) ? cur_q : run_id_q;
    idx_b      = tgt_q;

    case (walk_q)
      WALK_IDLE: begin
        if (ack_fire) begin
          lk_we      = 1'b1;
          lk_widx    = ack_id;
          lk_wval    = run_id_q;
          run_id_d   = ack_id;
          run_prio_d = {1'b0, ack_prio};
        end else if (eoi_take) begin
          if (eoi_id == run_id_q) begin
            run_id_d   = link_a;
            run_prio_d = link_a_known ? {1'b0, link_a_prio} : RP_IDLE;
          end else begin
            walk_d  = WALK_RUN;
            cur_d   = run_id_q;
            tgt_d   = eoi_id;
            steps_d = '0;
          end
        end
      end
      WALK_RUN: begin
        if (link_a == ID_NONE || steps_q == STEP_LAST) begin
          walk_d = WALK_IDLE;
        end else if (link_a == tgt_q) begin
          lk_we   = 1'b1;
          lk_widx = cur_q;
          lk_wval = link_b;
          walk_d  = WALK_IDLE;
        end else begin
          cur_d   = link_a;
          steps_d = steps_q + 1'b1;
        end
      end
      default: walk_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_q     <= WALK_IDLE;
      cur_q      <= ID_NONE;
      tgt_q      <= ID_NONE;
      steps_q    <= '0;
      run_id_q   <= ID_NONE;
      run_prio_q <= RP_IDLE;
    end else begin
      walk_q     <= walk_d;
      cur_q      <= cur_d;
      tgt_q      <= tgt_d;
      steps_q    <= steps_d;
      run_id_q   <= run_id_d;
      run_prio_q <= run_prio_d;
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;
  assign busy     = (walk_q == WALK_RUN);

  AST_IDLE_RUN_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id_q == ID_NONE) |-> (run_prio_q == RP_IDLE)); // R8
  AST_WALK_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_id_q)); // R9
endmodule

// File: rtl/aic_unit.sv
module aic_unit
  import aic_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_req,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_busy,
  input  logic [ID_W-1:0]           pend_id,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [NUM_IRQ-1:0]        src_enabled,
  input  logic [NUM_IRQ-1:0]        src_edge,
  input  logic [NUM_IRQ-1:0]        src_level,
  output logic                      irq_req,
  output logic                      clr_pend_vld,
  output logic [ID_W-1:0]           clr_pend_id,
  output logic                      repend_vld,
  output logic [ID_W-1:0]           repend_id
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  // bus edge detection and register state
  logic              req_q;
  logic              cpu_en_q, cpu_en_d;
  logic [ID_W-1:0]   mask_q, mask_d;
  logic [31:0]       rdata_q, rdata_d;
  logic              clr_vld_q, clr_vld_d;
  logic [ID_W-1:0]   clr_id_q, clr_id_d;
  logic              rep_vld_q, rep_vld_d;
  logic [ID_W-1:0]   rep_id_q, rep_id_d;

  logic              acc, rd_en, wr_en;
  logic              ack_fire, eoi_fire, eoi_take;
  logic [ID_W-1:0]   wr_id;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_id_known;

  logic [PRIO_W-1:0] pend_prio, link_prio;
  logic              pend_known, link_known;
  logic [ID_W-1:0]   hp_id;
  logic              ack_ok;

  logic [ID_W-1:0]   run_id;
  logic [PRIO_W:0]   run_prio;
  logic              busy;
  logic [ID_W-1:0]   idx_a, idx_b, link_a, link_b;
  logic              lk_we;
  logic [ID_W-1:0]   lk_widx, lk_wval;

  logic              unused_wdata;
  assign unused_wdata = ^bus_wdata[31:ID_W];

  aic_prio_lookup #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pend_prio (
    .idx(pend_id), .prio_flat(prio_flat), .prio(pend_prio), .known(pend_known)
  );

  aic_prio_lookup #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_link_prio (
    .idx(link_a), .prio_flat(prio_flat), .prio(link_prio), .known(link_known)
  );

  aic_qualify #(.PRIO_W(PRIO_W)) u_qual (
    .cpu_en(cpu_en_q), .mask(mask_q), .pend_id(pend_id), .pend_prio(pend_prio),
    .pend_known(pend_known), .run_prio(run_prio), .hp_id(hp_id), .ack_ok(ack_ok)
  );

  aic_link_store #(.NUM_IRQ(NUM_IRQ)) u_links (
    .clk(clk), .rst_n(rst_n), .we(lk_we), .widx(lk_widx), .wval(lk_wval),
    .idx_a(idx_a), .val_a(link_a), .idx_b(idx_b), .val_b(link_b)
  );

  aic_chain_ctl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .ack_fire(ack_fire), .ack_id(pend_id), .ack_prio(pend_prio),
    .eoi_fire(eoi_fire), .eoi_id(wr_id),
    .link_a(link_a), .link_b(link_b), .link_a_prio(link_prio), .link_a_known(link_known),
    .run_id(run_id), .run_prio(run_prio), .busy(busy), .eoi_take(eoi_take),
    .idx_a(idx_a), .idx_b(idx_b), .lk_we(lk_we), .lk_widx(lk_widx), .lk_wval(lk_wval)
  );

  // access decode
  always_comb begin
    acc         = bus_req && !req_q && !busy;
    rd_en       = acc && !bus_wr;
    wr_en       = acc && bus_wr;
    wr_id       = bus_wdata[ID_W-1:0];
    wr_idx      = bus_wdata[IDX_W-1:0];
    wr_id_known = (wr_id < ID_W'(NUM_IRQ));
    ack_fire    = rd_en && (bus_addr == ADDR_W'(OFS_ACK)) && ack_ok;
    eoi_fire    = wr_en && (bus_addr == ADDR_W'(OFS_EOI));
  end

  // next state of the register window
  always_comb begin
    cpu_en_d  = cpu_en_q;
    mask_d    = mask_q;
    rdata_d   = rdata_q;
    clr_vld_d = ack_fire;
    clr_id_d  = ack_fire ? pend_id : clr_id_q;
    rep_vld_d = 1'b0;
    rep_id_d  = rep_id_q;

    if (wr_en) begin
      if (bus_addr == ADDR_W'(OFS_CTRL)) cpu_en_d = bus_wdata[0];
      if (bus_addr == ADDR_W'(OFS_MASK)) mask_d   = wr_id;
    end

    if (eoi_take && wr_id_known) begin
      if (src_enabled[wr_idx] && !src_edge[wr_idx] && src_level[wr_idx]) begin
        rep_vld_d = 1'b1;
        rep_id_d  = wr_id;
      end
    end

    if (rd_en) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL): rdata_d = {31'd0, cpu_en_q};
        ADDR_W'(OFS_MASK): rdata_d = 32'(mask_q);
        ADDR_W'(OFS_BPNT): rdata_d = '0;
        ADDR_W'(OFS_ACK):  rdata_d = ack_ok ? 32'(pend_id) : 32'(ID_NONE);
        ADDR_W'(OFS_RUNP): rdata_d = 32'(run_prio);
        ADDR_W'(OFS_HPND): rdata_d = 32'(hp_id);
        default:           rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      cpu_en_q  <= 1'b0;
      mask_q    <= MASK_RESET;
      rdata_q   <= '0;
      clr_vld_q <= 1'b0;
      clr_id_q  <= ID_NONE;
      rep_vld_q <= 1'b0;
      rep_id_q  <= ID_NONE;
    end else begin
      req_q     <= bus_req;
      cpu_en_q  <= cpu_en_d;
      mask_q    <= mask_d;
      rdata_q   <= rdata_d;
      clr_vld_q <= clr_vld_d;
      clr_id_q  <= clr_id_d;
      rep_vld_q <= rep_vld_d;
      rep_id_q  <= rep_id_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign bus_busy     = busy;
  assign irq_req      = ack_ok;
  assign clr_pend_vld = clr_vld_q;
  assign clr_pend_id  = clr_id_q;
  assign repend_vld   = rep_vld_q;
  assign repend_id    = rep_id_q;

  AST_CLR_IS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld_q |-> (run_id == clr_id_q)); // R5
  AST_ACK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld_q |=> !clr_vld_q); // R6
  AST_REQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en_q |-> !irq_req); // R3
  AST_REPEND_NEEDS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    rep_vld_q |-> ($past(run_id) != ID_NONE)); // R7
endmodule

// File: tb/tb_aic_unit.sv
`timescale 1ns/1ps
module tb_aic_unit;
  localparam int NUM_IRQ = 64;
  localparam int PRIO_W  = 8;
  localparam logic [4:0] A_CTRL = 5'h00, A_MASK = 5'h04, A_BPNT = 5'h08, A_ACK = 5'h0C,
                         A_EOI = 5'h10, A_RUNP = 5'h14, A_HPND = 5'h18, A_HOLE = 5'h1C;
  localparam logic [9:0] NONE = 10'd1023;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic                      bus_req, bus_wr;
  logic [4:0]                bus_addr;
  logic [31:0]               bus_wdata, bus_rdata;
  logic                      bus_busy;
  logic [9:0]                pend_id;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [NUM_IRQ-1:0]        src_enabled, src_edge, src_level;
  logic                      irq_req, clr_pend_vld, repend_vld;
  logic [9:0]                clr_pend_id, repend_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  aic_unit #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_busy(bus_busy), .pend_id(pend_id),
    .prio_flat(prio_flat), .src_enabled(src_enabled), .src_edge(src_edge),
    .src_level(src_level), .irq_req(irq_req), .clr_pend_vld(clr_pend_vld),
    .clr_pend_id(clr_pend_id), .repend_vld(repend_vld), .repend_id(repend_id)
  );

  function automatic logic [31:0] prio_of(input int id);
    return 32'((id * 3) & 255);
  endfunction

  // vector: {req[3:0], wr, addr[4:0], wdata[31:0], pend[9:0], exp[31:0], chk}
  localparam int NV = 29;
  localparam logic [84:0] VEC [NV] = '{
    {4'd1,  1'b0, A_CTRL, 32'h0,        NONE,   32'h0,   1'b1},
    {4'd1,  1'b0, A_MASK, 32'h0,        NONE,   32'h0F0, 1'b1},
    {4'd1,  1'b0, A_RUNP, 32'h0,        NONE,   32'h100, 1'b1},
    {4'd1,  1'b0, A_HPND, 32'h0,        10'd10, 32'h3FF, 1'b1},
    {4'd4,  1'b0, A_ACK,  32'h0,        10'd10, 32'h3FF, 1'b1},
    {4'd2,  1'b1, A_CTRL, 32'h1,        NONE,   32'h0,   1'b0},
    {4'd2,  1'b0, A_CTRL, 32'h0,        NONE,   32'h1,   1'b1},
    {4'd3,  1'b0, A_HPND, 32'h0,        10'd10, 32'h00A, 1'b1},
    {4'd2,  1'b1, A_MASK, 32'hFFFFF010, NONE,   32'h0,   1'b0},
    {4'd2,  1'b0, A_MASK, 32'h0,        NONE,   32'h010, 1'b1},
    {4'd3,  1'b0, A_HPND, 32'h0,        10'd10, 32'h3FF, 1'b1},
    {4'd2,  1'b1, A_MASK, 32'h0F0,      NONE,   32'h0,   1'b0},
    {4'd2,  1'b1, A_BPNT, 32'h55,       NONE,   32'h0,   1'b0},
    {4'd2,  1'b0, A_BPNT, 32'h0,        NONE,   32'h0,   1'b1},
    {4'd3,  1'b0, A_HPND, 32'h0,        10'd63, 32'h03F, 1'b1},
    {4'd5,  1'b0, A_ACK,  32'h0,        10'd10, 32'h00A, 1'b1},
    {4'd5,  1'b0, A_RUNP, 32'h0,        NONE,   32'h01E, 1'b1},
    {4'd4,  1'b0, A_ACK,  32'h0,        10'd20, 32'h3FF, 1'b1},
    {4'd3,  1'b0, A_HPND, 32'h0,        10'd20, 32'h014, 1'b1},
    {4'd5,  1'b0, A_ACK,  32'h0,        10'd5,  32'h005, 1'b1},
    {4'd5,  1'b0, A_RUNP, 32'h0,        NONE,   32'h00F, 1'b1},
    {4'd8,  1'b1, A_EOI,  32'h5,        NONE,   32'h0,   1'b0},
    {4'd8,  1'b0, A_RUNP, 32'h0,        NONE,   32'h01E, 1'b1},
    {4'd8,  1'b1, A_EOI,  32'hA,        NONE,   32'h0,   1'b0},
    {4'd8,  1'b0, A_RUNP, 32'h0,        NONE,   32'h100, 1'b1},
    {4'd7,  1'b1, A_EOI,  32'hA,        NONE,   32'h0,   1'b0},
    {4'd7,  1'b0, A_RUNP, 32'h0,        NONE,   32'h100, 1'b1},
    {4'd4,  1'b0, A_ACK,  32'h0,        NONE,   32'h3FF, 1'b1},
    {4'd2,  1'b0, A_HOLE, 32'h0,        NONE,   32'h0,   1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  logic [31:0] rd_v;
  bit          clr_s, rep_s;
  logic [9:0]  clr_id_s, rep_id_s;

  // one access: idle cycle, strobe for one cycle, sample after the edge
  task automatic access(input bit w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    while (bus_busy) @(negedge clk);
    bus_req = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req  = 1'b0;
    rd_v     = bus_rdata;
    clr_s    = clr_pend_vld;
    clr_id_s = clr_pend_id;
    rep_s    = repend_vld;
    rep_id_s = repend_id;
  endtask

  task automatic wait_idle();
    while (bus_busy) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int pulses;
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pend_id = NONE; src_enabled = '0; src_edge = '0; src_level = '0;
    for (int i = 0; i < NUM_IRQ; i++) prio_flat[i*PRIO_W +: PRIO_W] = prio_of(i)[PRIO_W-1:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // table walk: R1 reset values, R2 map, R3 qualify, R4/R5 ack, R7/R8 completion
    for (int v = 0; v < NV; v++) begin
      pend_id = VEC[v][42:33];
      access(VEC[v][80], VEC[v][79:75], VEC[v][74:43]);
      if (VEC[v][0]) check($sformatf("R%0d vector %0d", VEC[v][84:81], v), rd_v, VEC[v][32:1]);
    end

    // R3 / R5: request line
    pend_id = 10'd10;
    @(negedge clk);
    check("R3 request with idle running", 32'(irq_req), 32'd1);
    access(1'b0, A_ACK, 32'h0);
    check("R5 ack returns id", rd_v, 32'd10);
    check("R5 clear strobe", {31'd0, clr_s}, 32'd1);
    check("R5 clear id", 32'(clr_id_s), 32'd10);
    check("R5 request falls", 32'(irq_req), 32'd0);
    pend_id = 10'd5;
    @(negedge clk);
    check("R3 request for preempting id", 32'(irq_req), 32'd1);
    access(1'b1, A_EOI, 32'd10);
    access(1'b1, A_CTRL, 32'h0);
    check("R3 request off when disabled", 32'(irq_req), 32'd0);
    access(1'b1, A_CTRL, 32'h1);

    // R6: held strobe acts once
    pend_id = 10'd10;
    @(negedge clk);
    pulses = 0;
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = A_ACK;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (clr_pend_vld) pulses++;
    end
    bus_req = 1'b0;
    @(negedge clk);
    if (clr_pend_vld) pulses++;
    check("R6 single clear strobe", 32'(pulses), 32'd1);
    check("R6 read data", bus_rdata, 32'd10);
    access(1'b0, A_RUNP, 32'h0);
    check("R6 running priority", rd_v, prio_of(10));
    access(1'b1, A_EOI, 32'd10);

    // R9: chain 1 -> 2 -> 5 -> 10, complete 10 from the chain tail
    pend_id = 10'd10; access(1'b0, A_ACK, 32'h0);
    pend_id = 10'd5;  access(1'b0, A_ACK, 32'h0);
    pend_id = 10'd2;  access(1'b0, A_ACK, 32'h0);
    pend_id = 10'd1;  access(1'b0, A_ACK, 32'h0);
    check("R9 nested ack", rd_v, 32'd1);
    pend_id = NONE;
    access(1'b1, A_EOI, 32'd10);
    check("R9 busy during walk", 32'(bus_busy), 32'd1);
    @(negedge clk);
    check("R9 still busy", 32'(bus_busy), 32'd1);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_MASK; bus_wdata = 32'h1;
    @(negedge clk);
    bus_req = 1'b0;
    wait_idle();
    access(1'b0, A_MASK, 32'h0);
    check("R9 write while busy dropped", rd_v, 32'h0F0);
    access(1'b0, A_RUNP, 32'h0);
    check("R9 running kept", rd_v, prio_of(1));
    access(1'b1, A_EOI, 32'd1);
    access(1'b0, A_RUNP, 32'h0);
    check("R9 after first unwind", rd_v, prio_of(2));
    access(1'b1, A_EOI, 32'd2);
    access(1'b0, A_RUNP, 32'h0);
    check("R9 after second unwind", rd_v, prio_of(5));
    access(1'b1, A_EOI, 32'd5);
    access(1'b0, A_RUNP, 32'h0);
    check("R9 spliced id skipped", rd_v, 32'h100);

    // R10: level source re-pend
    src_enabled[12] = 1'b1; src_level[12] = 1'b1; src_edge[12] = 1'b0;
    pend_id = 10'd12; access(1'b0, A_ACK, 32'h0);
    pend_id = NONE;
    access(1'b1, A_EOI, 32'd12);
    check("R10 re-pend strobe", {31'd0, rep_s}, 32'd1);
    check("R10 re-pend id", 32'(rep_id_s), 32'd12);
    src_edge[12] = 1'b1;
    pend_id = 10'd12; access(1'b0, A_ACK, 32'h0);
    pend_id = NONE;
    access(1'b1, A_EOI, 32'd12);
    check("R10 edge source not re-pended", {31'd0, rep_s}, 32'd0);

    // R7: completion while idle is ignored, no re-pend
    src_edge[12] = 1'b0;
    access(1'b1, A_EOI, 32'd12);
    check("R7 idle completion no re-pend", {31'd0, rep_s}, 32'd0);

    // R1: reset in the middle of activity
    pend_id = 10'd10; access(1'b0, A_ACK, 32'h0);
    access(1'b1, A_MASK, 32'h33);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, A_RUNP, 32'h0);
    check("R1 running priority after reset", rd_v, 32'h100);
    access(1'b0, A_MASK, 32'h0);
    check("R1 mask after reset", rd_v, 32'h0F0);
    access(1'b0, A_ACK, 32'h0);
    check("R1 ack after reset", rd_v, 32'h3FF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule